// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a simple request port and an asynchronous 4M x 4 dynamic RAM. Each request carries a 22-bit word address, a 4-bit write word and two flags. The block turns each request into the strobe sequence the memory needs. The upper 11 address bits select the row and are presented first on the shared 11-bit address pins. The lower 11 bits then select the column. All delays are counted in system clock cycles set by module parameters.

After an access the row strobe stays low and the row is left open. A later request to the same row runs as a page cycle, which only pulses the column strobe with a new column address. A request to a different row first closes the open row, waits out the precharge time and then opens the new row. Writes use early-write sequencing. A read-modify-write request returns the old word and stores the new word, both within one row-open period. The row is closed on its own before the row-strobe low-time limit is reached. An external refresh scheduler can ask for the memory; the block finishes any access in flight, closes the row and grants the bus.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held and just after it is released, rowStrobeN, colStrobeN, writeEnN and outEnN are 1, dqDrive is 0, rdValid and refreshGrant are 0, and reqReady is 1.
- R2: The row half, address bits 21..11, is on memAddr when rowStrobeN falls. The column half, bits 10..0, is on memAddr when colStrobeN falls.
- R3: A read returns the word stored at its address on rdData, with rdValid high for exactly one cycle. From a closed row this happens T_RP+T_RCD+T_CAS+2 cycles after the accepting edge.
- R4: For a write, writeEnN is already 0 and dqDrive is 1 when colStrobeN falls, and outEnN stays 1 for the whole access. writeEnN and outEnN are never both 0.
- R5: A request to the open row keeps rowStrobeN low, with no new row strobe fall. A read of this kind completes in T_CAS+2 cycles.
- R6: rowStrobeN is high for at least T_RP consecutive cycles before each fall.
- R7: A read-modify-write returns the old word with page-read timing, then stores the new word at the same address in the same row-open period. outEnN has returned to 1 before dqDrive is raised.
- R8: While refreshReq is high, an access already in progress completes, the open row is closed and refreshGrant is raised. During the grant, rowStrobeN and colStrobeN are 1 and reqReady is 0. After the grant, the row is no longer open.
- R9: rowStrobeN is never low for T_RAS_MAX or more consecutive cycles. An idle open row is closed on its own before that limit is reached.
- R10: colStrobeN is low only while rowStrobeN is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted on this edge when valid |
| reqAddr | input | 22 | Word address, row in the upper half |
| reqWrite | input | 1 | Request is a write |
| reqRmw | input | 1 | Request is a read-modify-write (overrides reqWrite) |
| reqWdata | input | 4 | Word to store |
| rdValid | output | 1 | One-cycle pulse, rdData valid |
| rdData | output | 4 | Word read |
| refreshReq | input | 1 | Refresh scheduler wants the memory |
| refreshGrant | output | 1 | Memory idle and handed to the scheduler |
| memAddr | output | 11 | Multiplexed row/column address pins |
| rowStrobeN | output | 1 | Row strobe, active low |
| colStrobeN | output | 1 | Column strobe, active low |
| writeEnN | output | 1 | Write enable, active low |
| outEnN | output | 1 | Output enable, active low |
| dqOut | output | 4 | Data to the memory |
| dqDrive | output | 1 | Controller drives the data pins |
| dqIn | input | 4 | Data from the memory |

## Verification
Read data is due a fixed number of cycles after the edge that accepts the request. A page hit takes T_CAS+2 cycles. A closed or missed row takes T_RP+T_RCD+T_CAS+2 cycles, because precharge, row-to-column delay, column setup and the capture register all lie in the path. The bench marks the accepting edge itself, counts falling clock edges up to rdValid and compares the count with these sums. The memory model latches the row and column on the strobe edges. Monitors sampled at each rising edge record strobe runs, strobe falls and output-enable activity, and the bench reads them only after a scenario has finished.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [3:0] {
    S_IDLE,      // row closed, nothing open
    S_PRE,       // row strobe high, precharge before opening
    S_RCD,       // row strobe low, row address held
    S_COLSETUP,  // column address set up, column strobe still high
    S_CAS,       // column strobe low (read, write or rmw read half)
    S_TURN,      // rmw: output enable released, bus idle
    S_WR,        // rmw: write half
    S_CPRE,      // column strobe precharge
    S_OPEN,      // row open, waiting for a request
    S_CLOSE,     // row strobe high before going idle
    S_REF        // bus granted to the refresh scheduler
  } ctrl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic selCol;
    logic capture;
    logic driveDq;
  } dp_strobe_t;

endpackage

// File: rtl/fpm_ctrl_fsm.sv
module fpm_ctrl_fsm
  import fpm_pkg::*;
#(
  parameter int T_RP      = 6,
  parameter int T_RCD     = 4,
  parameter int T_CAS     = 3,
  parameter int T_CP      = 2,
  parameter int T_RAS_MAX = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic       rowHit,
  input  logic       isWrite,
  input  logic       isRmw,
  input  logic       refreshReq,
  output logic       refreshGrant,
  output dp_strobe_t dpStrb,
  output logic       rasN,
  output logic       casN,
  output logic       weN,
  output logic       oeN
);

  localparam int MAX_A   = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int MAX_B   = (T_CAS > T_CP) ? T_CAS : T_CP;
  localparam int CNT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  // worst-case row-low cycles added once a request is accepted in S_OPEN
  localparam int ACCESS_MAX = 2 * T_CAS + T_CP + 4;
  localparam int OPEN_LIMIT = T_RAS_MAX - ACCESS_MAX;
  localparam int RAS_W      = $clog2(T_RAS_MAX + 1);

  ctrl_state_e state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic [RAS_W-1:0] rasCnt;
  logic cntDone, rasLimit;

  assign cntDone  = (cnt == '0);
  assign rasLimit = (rasCnt >= RAS_W'(OPEN_LIMIT));

  always_comb begin
    reqReady = ((state == S_IDLE) && !refreshReq) ||
               ((state == S_OPEN) && !refreshReq && !rasLimit);
    nextState = state;
    nextCnt   = cntDone ? cnt : cnt - 1'b1;
    case (state)
      S_IDLE: begin
        if (refreshReq) nextState = S_REF;
        else if (reqValid) begin
          nextState = S_PRE;
          nextCnt   = CNT_W'(T_RP - 1);
        end
      end
      S_REF:  if (!refreshReq) nextState = S_IDLE;
      S_PRE: begin
        if (cntDone) begin
          nextState = S_RCD;
          nextCnt   = CNT_W'(T_RCD - 1);
        end
      end
      S_RCD:  if (cntDone) nextState = S_COLSETUP;
      S_COLSETUP: begin
        nextState = S_CAS;
        nextCnt   = CNT_W'(T_CAS - 1);
      end
      S_CAS: begin
        if (cntDone) begin
          if (isRmw) nextState = S_TURN;
          else begin
            nextState = S_CPRE;
            nextCnt   = CNT_W'(T_CP - 1);
          end
        end
      end
      S_TURN: begin
        nextState = S_WR;
        nextCnt   = CNT_W'(T_CAS - 1);
      end
      S_WR: begin
        if (cntDone) begin
          nextState = S_CPRE;
          nextCnt   = CNT_W'(T_CP - 1);
        end
      end
      S_CPRE: if (cntDone) nextState = S_OPEN;
      S_OPEN: begin
        if (refreshReq || rasLimit) begin
          nextState = S_CLOSE;
          nextCnt   = CNT_W'(T_RP - 1);
        end else if (reqValid) begin
          if (rowHit) nextState = S_COLSETUP;
          else begin
            nextState = S_PRE;
            nextCnt   = CNT_W'(T_RP - 1);
          end
        end
      end
      S_CLOSE: if (cntDone) nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  // pin and datapath strobes decoded from the current state
  always_comb begin
    rasN = state inside {S_IDLE, S_PRE, S_CLOSE, S_REF};
    casN = !(state inside {S_CAS, S_TURN, S_WR});
    dpStrb.latchReq = reqReady && reqValid;
    dpStrb.selCol   = state inside {S_COLSETUP, S_CAS, S_TURN, S_WR, S_CPRE};
    dpStrb.driveDq  = ((state inside {S_COLSETUP, S_CAS}) && isWrite) ||
                      (state == S_WR);
    dpStrb.capture  = (state == S_CAS) && cntDone && !isWrite;
    weN             = !dpStrb.driveDq;
    oeN             = !((state == S_CAS) && !isWrite);
    refreshGrant    = (state == S_REF);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cnt    <= '0;
      rasCnt <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      if (rasN) rasCnt <= '0;
      else if (rasCnt < RAS_W'(T_RAS_MAX)) rasCnt <= rasCnt + 1'b1;
    end
  end

endmodule

// File: rtl/fpm_datapath.sv
module fpm_datapath
  import fpm_pkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 11,
  parameter int DATA_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dp_strobe_t               dpStrb,
  input  logic [ROW_W+COL_W-1:0]   reqAddr,
  input  logic                     reqWrite,
  input  logic                     reqRmw,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic [DATA_W-1:0]        dqIn,
  output logic                     rowHit,
  output logic                     isWrite,
  output logic                     isRmw,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] memAddr,
  output logic [DATA_W-1:0]        dqOut,
  output logic                     dqDrive,
  output logic                     rdValid,
  output logic [DATA_W-1:0]        rdData
);

  localparam int ADDR_W = ROW_W + COL_W;
  localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic [ROW_W-1:0]  rowReg;
  logic [COL_W-1:0]  colReg;
  logic [DATA_W-1:0] wdataReg;

  // the most recently accepted row is the open row whenever control is in S_OPEN
  assign rowHit  = (reqAddr[ADDR_W-1:COL_W] == rowReg);
  assign memAddr = dpStrb.selCol ? PIN_W'(colReg) : PIN_W'(rowReg);
  assign dqOut   = wdataReg;
  assign dqDrive = dpStrb.driveDq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowReg   <= '0;
      colReg   <= '0;
      wdataReg <= '0;
      isWrite  <= 1'b0;
      isRmw    <= 1'b0;
      rdValid  <= 1'b0;
      rdData   <= '0;
    end else begin
      if (dpStrb.latchReq) begin
        rowReg   <= reqAddr[ADDR_W-1:COL_W];
        colReg   <= reqAddr[COL_W-1:0];
        wdataReg <= reqWdata;
        isWrite  <= reqWrite && !reqRmw;
        isRmw    <= reqRmw;
      end
      rdValid <= dpStrb.capture;
      if (dpStrb.capture) rdData <= dqIn;
    end
  end

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int ROW_W     = 11,
  parameter int COL_W     = 11,
  parameter int DATA_W    = 4,
  parameter int T_RP      = 6,
  parameter int T_RCD     = 4,
  parameter int T_CAS     = 3,
  parameter int T_CP      = 2,
  parameter int T_RAS_MAX = 2000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [ROW_W+COL_W-1:0] reqAddr,
  input  logic                   reqWrite,
  input  logic                   reqRmw,
  input  logic [DATA_W-1:0]      reqWdata,
  output logic                   rdValid,
  output logic [DATA_W-1:0]      rdData,
  input  logic                   refreshReq,
  output logic                   refreshGrant,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] memAddr,
  output logic                   rowStrobeN,
  output logic                   colStrobeN,
  output logic                   writeEnN,
  output logic                   outEnN,
  output logic [DATA_W-1:0]      dqOut,
  output logic                   dqDrive,
  input  logic [DATA_W-1:0]      dqIn
);

  dp_strobe_t dpStrb;
  logic rowHit, isWrite, isRmw;

  fpm_ctrl_fsm #(
    .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RAS_MAX(T_RAS_MAX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .rowHit(rowHit), .isWrite(isWrite), .isRmw(isRmw),
    .refreshReq(refreshReq), .refreshGrant(refreshGrant), .dpStrb(dpStrb),
    .rasN(rowStrobeN), .casN(colStrobeN), .weN(writeEnN), .oeN(outEnN)
  );

  fpm_datapath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dpStrb(dpStrb), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqRmw(reqRmw), .reqWdata(reqWdata), .dqIn(dqIn),
    .rowHit(rowHit), .isWrite(isWrite), .isRmw(isRmw), .memAddr(memAddr),
    .dqOut(dqOut), .dqDrive(dqDrive), .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: rtl/fpm_dram_checker.sv
module fpm_dram_checker #(
  parameter int T_RP      = 6,
  parameter int T_RAS_MAX = 2000
) (
  input logic clk,
  input logic rstN,
  input logic rowStrobeN,
  input logic colStrobeN,
  input logic writeEnN,
  input logic outEnN,
  input logic dqDrive,
  input logic rdValid,
  input logic refreshGrant
);

  int lowRun;
  int highRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun  <= 0;
      highRun <= 0;
    end else begin
      lowRun  <= rowStrobeN ? 0 : lowRun + 1;
      highRun <= !rowStrobeN ? 0 : ((highRun < T_RP) ? highRun + 1 : highRun);
    end
  end

  assert_ras_low_limit_R9: assert property (@(posedge clk) disable iff (!rstN)
    lowRun < T_RAS_MAX);

  assert_precharge_time_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rowStrobeN) |-> highRun >= T_RP);

  assert_cas_inside_ras_R10: assert property (@(posedge clk) disable iff (!rstN)
    !colStrobeN |-> !rowStrobeN);

  assert_no_we_with_oe_R4: assert property (@(posedge clk) disable iff (!rstN)
    !writeEnN |-> outEnN);

  assert_bus_released_R7: assert property (@(posedge clk) disable iff (!rstN)
    dqDrive |-> outEnN);

  assert_grant_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    refreshGrant |-> (rowStrobeN && colStrobeN));

  assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

endmodule

bind fpm_dram_ctrl fpm_dram_checker #(.T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) u_chk (
  .clk(clk), .rstN(rstN), .rowStrobeN(rowStrobeN), .colStrobeN(colStrobeN),
  .writeEnN(writeEnN), .outEnN(outEnN), .dqDrive(dqDrive), .rdValid(rdValid),
  .refreshGrant(refreshGrant)
);

// File: tb/fpm_dram_ctrl_tb.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_tb;

  localparam int TRP = 2, TRCD = 2, TCAS = 2, TCP = 1, TRASMAX = 40;
  localparam int LAT_HIT  = TCAS + 2;
  localparam int LAT_MISS = TRP + TRCD + TCAS + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        reqValid = 1'b0, reqWrite = 1'b0, reqRmw = 1'b0, refreshReq = 1'b0;
  logic [21:0] reqAddr = '0;
  logic [3:0]  reqWdata = '0;
  logic        reqReady, rdValid, refreshGrant;
  logic [3:0]  rdData, dqOut, dqIn;
  logic [10:0] memAddr;
  logic        rowStrobeN, colStrobeN, writeEnN, outEnN, dqDrive;

  fpm_dram_ctrl #(.T_RP(TRP), .T_RCD(TRCD), .T_CAS(TCAS), .T_CP(TCP), .T_RAS_MAX(TRASMAX)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqRmw(reqRmw), .reqWdata(reqWdata), .rdValid(rdValid),
    .rdData(rdData), .refreshReq(refreshReq), .refreshGrant(refreshGrant),
    .memAddr(memAddr), .rowStrobeN(rowStrobeN), .colStrobeN(colStrobeN),
    .writeEnN(writeEnN), .outEnN(outEnN), .dqOut(dqOut), .dqDrive(dqDrive), .dqIn(dqIn)
  );

  // ---------------- memory model ----------------
  logic [3:0]  mem [logic [21:0]];
  logic [10:0] mRow = '0, mCol = '0;
  logic [3:0]  mRd = '0;
  bit          mEarly = 0, mDriveAtWr = 0;
  int          mLateWrites = 0;

  always @(negedge rowStrobeN) mRow = memAddr;
  always @(negedge colStrobeN) begin
    mCol = memAddr;
    mRd  = mem.exists({mRow, mCol}) ? mem[{mRow, mCol}] : 4'h0;
    mEarly = !writeEnN;
    if (!writeEnN) begin
      mem[{mRow, mCol}] = dqOut;
      mDriveAtWr = dqDrive;
    end
  end
  always @(negedge writeEnN) begin
    if (!colStrobeN) begin
      mem[{mRow, mCol}] = dqOut;
      mLateWrites++;
    end
  end
  assign dqIn = (!colStrobeN && !outEnN && writeEnN) ? mRd : 4'h0;

  // ---------------- monitors ----------------
  int rasFalls = 0, oeLowCnt = 0, casOutCnt = 0, grantCnt = 0;
  int lowRun = 0, maxLowRun = 0, highRun = 0, lastHighRun = 0;
  logic prevRas = 1'b1;
  always @(posedge clk) begin
    if (rstN) begin
      if (prevRas && !rowStrobeN) begin
        rasFalls++;
        lastHighRun = highRun;
      end
      if (rowStrobeN) begin highRun++; lowRun = 0; end
      else begin
        highRun = 0; lowRun++;
        if (lowRun > maxLowRun) maxLowRun = lowRun;
      end
      if (!outEnN) oeLowCnt++;
      if (!colStrobeN && rowStrobeN) casOutCnt++;
      if (refreshGrant) grantCnt++;
      prevRas = rowStrobeN;
    end
  end

  // ---------------- bookkeeping ----------------
  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- access helpers ----------------
  task automatic issue(input logic [21:0] a, input bit wr, input bit rmw, input logic [3:0] wd);
    @(negedge clk);
    reqValid = 1; reqAddr = a; reqWrite = wr; reqRmw = rmw; reqWdata = wd;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    #1;
    reqValid = 0; reqWrite = 0; reqRmw = 0;
  endtask

  task automatic waitRd(output logic [3:0] d, output int lat);
    lat = 0;
    do begin @(negedge clk); lat++; end while (!rdValid && lat < 200);
    d = rdData;
  endtask

  task automatic waitIdle();
    int n = 0;
    do begin @(negedge clk); n++; end while (!reqReady && n < 200);
  endtask

  task automatic doRead(input logic [21:0] a, output logic [3:0] d, output int lat);
    issue(a, 0, 0, 4'h0);
    waitRd(d, lat);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rstN = 0;
    repeat (3) @(negedge clk);
    chk(rowStrobeN && colStrobeN && writeEnN && outEnN, "R1 strobes high in reset", 0, 1);
    chk(!dqDrive && !rdValid && !refreshGrant, "R1 outputs idle in reset", int'(dqDrive), 0);
    rstN = 1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready after reset", int'(reqReady), 1);
    chk(rowStrobeN && !refreshGrant, "R1 row closed after reset", int'(rowStrobeN), 1);
  endtask

  task automatic t_miss_read();
    logic [3:0] d; int lat;
    mem[{11'd5, 11'd7}] = 4'h9;
    doRead({11'd5, 11'd7}, d, lat);
    chk(d == 4'h9, "R3 read data closed row", d, 9);
    chk(lat == LAT_MISS, "R3 closed-row read latency", lat, LAT_MISS);
    chk(mRow == 11'd5, "R2 row half at row strobe", mRow, 5);
    chk(mCol == 11'd7, "R2 column half at column strobe", mCol, 7);
  endtask

  task automatic t_page_hit();
    logic [3:0] d; int lat; int f;
    f = rasFalls;
    mem[{11'd5, 11'd300}] = 4'hC;
    doRead({11'd5, 11'd300}, d, lat);
    chk(d == 4'hC, "R5 page hit data", d, 12);
    chk(lat == LAT_HIT, "R5 page hit latency", lat, LAT_HIT);
    chk(rasFalls == f, "R5 no row strobe fall on hit", rasFalls, f);
    chk(mCol == 11'd300, "R2 new column on page hit", mCol, 300);
    @(negedge clk);
    chk(rdValid == 1'b0, "R3 rdValid single cycle", int'(rdValid), 0);
  endtask

  task automatic t_write();
    logic [3:0] d; int lat; int f, o;
    f = rasFalls; o = oeLowCnt;
    issue({11'd5, 11'd9}, 1, 0, 4'h6);
    waitIdle();
    chk(mem[{11'd5, 11'd9}] == 4'h6, "R4 word stored", mem[{11'd5, 11'd9}], 6);
    chk(mEarly, "R4 write enable low before column strobe", int'(mEarly), 1);
    chk(mDriveAtWr, "R4 data driven at column strobe", int'(mDriveAtWr), 1);
    chk(oeLowCnt == o, "R4 output enable held high", oeLowCnt - o, 0);
    chk(rasFalls == f, "R5 write page hit keeps row", rasFalls, f);
    doRead({11'd5, 11'd9}, d, lat);
    chk(d == 4'h6, "R4 read back written word", d, 6);
    chk(lat == LAT_HIT, "R5 read back latency", lat, LAT_HIT);
  endtask

  task automatic t_row_miss();
    logic [3:0] d; int lat;
    mem[{11'd1234, 11'd2047}] = 4'h3;
    doRead({11'd1234, 11'd2047}, d, lat);
    chk(d == 4'h3, "R6 row miss data", d, 3);
    chk(lat == LAT_MISS, "R6 row miss latency", lat, LAT_MISS);
    chk(lastHighRun >= TRP, "R6 precharge length", lastHighRun, TRP);
    chk(mRow == 11'd1234 && mCol == 11'd2047, "R2 top address bits", mRow, 1234);
  endtask

  task automatic t_rmw();
    logic [3:0] d; int lat; int f, w;
    f = rasFalls; w = mLateWrites;
    mem[{11'd1234, 11'd5}] = 4'hA;
    issue({11'd1234, 11'd5}, 0, 1, 4'h5);
    waitRd(d, lat);
    chk(d == 4'hA, "R7 old word returned", d, 10);
    chk(lat == LAT_HIT, "R7 read half latency", lat, LAT_HIT);
    waitIdle();
    chk(mem[{11'd1234, 11'd5}] == 4'h5, "R7 new word stored", mem[{11'd1234, 11'd5}], 5);
    chk(mLateWrites == w + 1, "R7 write inside column strobe", mLateWrites - w, 1);
    chk(rasFalls == f, "R7 one row-open period", rasFalls, f);
    doRead({11'd1234, 11'd5}, d, lat);
    chk(d == 4'h5, "R7 read back after rmw", d, 5);
  endtask

  task automatic t_refresh_idle();
    logic [3:0] d; int lat; int n, f;
    @(negedge clk);
    refreshReq = 1;
    n = 0;
    while (!refreshGrant && n < 100) begin @(negedge clk); n++; end
    chk(refreshGrant == 1'b1, "R8 grant raised", int'(refreshGrant), 1);
    chk(rowStrobeN && colStrobeN, "R8 row closed at grant", int'(rowStrobeN), 1);
    f = rasFalls;
    reqValid = 1; reqAddr = {11'd1234, 11'd6};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!reqReady && refreshGrant, "R8 requests held off during grant", int'(reqReady), 0);
    end
    chk(rasFalls == f, "R8 no row opened during grant", rasFalls, f);
    reqValid = 0;
    refreshReq = 0;
    @(negedge clk);
    mem[{11'd1234, 11'd6}] = 4'h7;
    doRead({11'd1234, 11'd6}, d, lat);
    chk(d == 4'h7, "R8 data after refresh", d, 7);
    chk(lat == LAT_MISS, "R8 row reopened after refresh", lat, LAT_MISS);
  endtask

  task automatic t_refresh_busy();
    logic [3:0] d; int lat; int g, n;
    g = grantCnt;
    mem[{11'd1234, 11'd8}] = 4'hE;
    issue({11'd1234, 11'd8}, 0, 0, 4'h0);
    refreshReq = 1;
    waitRd(d, lat);
    chk(d == 4'hE, "R8 access in flight completes", d, 14);
    chk(grantCnt == g, "R8 no grant before access ends", grantCnt - g, 0);
    n = 0;
    while (!refreshGrant && n < 100) begin @(negedge clk); n++; end
    chk(refreshGrant && rowStrobeN, "R8 grant after access", int'(refreshGrant), 1);
    refreshReq = 0;
    @(negedge clk);
  endtask

  task automatic t_ras_limit();
    logic [3:0] d; int lat; int f;
    mem[{11'd77, 11'd1}] = 4'h2;
    doRead({11'd77, 11'd1}, d, lat);
    repeat (60) @(negedge clk);
    chk(rowStrobeN == 1'b1, "R9 idle row closed by itself", int'(rowStrobeN), 1);
    chk(maxLowRun < TRASMAX, "R9 low time under limit idle", maxLowRun, TRASMAX - 1);
    f = rasFalls;
    for (int i = 0; i < 16; i++) mem[{11'd77, 11'(i)}] = 4'(i ^ 5);
    for (int i = 0; i < 16; i++) begin
      doRead({11'd77, 11'(i)}, d, lat);
      chk(d == 4'(i ^ 5), "R9 stream data", d, i ^ 5);
      chk(lat == LAT_HIT || lat == LAT_MISS, "R9 stream latency", lat, LAT_HIT);
    end
    chk(maxLowRun < TRASMAX, "R9 low time under limit streaming", maxLowRun, TRASMAX - 1);
    chk(rasFalls >= f + 2, "R9 row reopened during stream", rasFalls - f, 2);
  endtask

  initial begin
    t_reset();
    t_miss_read();
    t_page_hit();
    t_write();
    t_row_miss();
    t_rmw();
    t_refresh_idle();
    t_refresh_busy();
    t_ras_limit();
    repeat (5) @(negedge clk);
    chk(casOutCnt == 0, "R10 column strobe only inside row strobe", casOutCnt, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule